// File: doc/BRIEF.md
# Parallel Port Register File

This block is the processor-facing side of a three-port, 24-line parallel interface. A small synchronous bus (chip select, read and write strobes, a two-bit address and an 8-bit data word) reaches three 8-bit port latches and one write-only control word. The block drives direction enables for each port and the latched basic-mode output values. It also passes the group mode settings on to the separate handshake channels, which own the port C lines that they use.

The control address carries two command formats, and bit 7 of the written word chooses between them. With bit 7 set, the word is a mode set. It reprograms both port groups and returns every output latch to zero. With bit 7 clear, the word is an atomic set or clear of a single port C bit. That second form is the only way to change the upper port C nibble. A port C read merges the live pins, the output latch and the status bits that the handshake channels supply, so software can poll the status with an ordinary read.

The strobes are sampled on the block clock. A write takes effect once, on the first cycle in which the strobe is seen active.

Top module: `ppi_regfile`

## Requirements
- R1: After reset all 24 lines are inputs (`pa_oe`=0, `pb_oe`=0, `pc_oe`=0), all output latches are 0, both group modes read as 0 and `dout_en` is 0.
- R2: A write to address 0 loads the port A latch and a write to address 1 loads the port B latch, both from `din`.
- R3: A control write (address 3) with bit 7 = 1 sets the configuration. Bits 6:5 give the group A mode (00 basic, 01 strobed, 1x bidirectional). Bit 4 sets the port A direction, bit 3 the port C upper direction, bit 2 the group B mode, bit 1 the port B direction and bit 0 the port C lower direction. A direction bit of 1 means input, so the output enable is 0.
- R4: Every mode-set write clears the port A, port B and port C output latches to 0.
- R5: A control write with bit 7 = 0 sets (bit 0 = 1) or clears (bit 0 = 0) the port C latch bit indexed by bits 3:1. The other latch bits keep their values, and bits 6:4 have no effect.
- R6: A write to address 2 updates only port C latch bits 3:0. Bits 7:4 keep their values.
- R7: `dout_en` is 1 only while `cs_n`=0, `rd_n`=0, `wr_n`=1 and the address is not 3. A read at address 3 leaves the bus released.
- R8: A read of port A or port B returns the latch when that port is an output, and the live pins when it is an input.
- R9: A port C read returns, for each bit, `hs_status` where `hs_owned` is 1. Where `hs_owned` is 0 it returns the latch bit if that bit is an output, and otherwise the live pin.
- R10: The port C upper output enables are 0 unless group A is in mode 0. The lower ones are 0 unless group B is in mode 0. `pa_oe` is 0 whenever group A is in mode 2.
- R11: Chip select high, or both strobes low together, performs no write.
- R12: A write strobe held low for several cycles performs exactly one write, using the data of its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 control |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_en | output | 1 | Read data bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin values |
| hs_owned | input | 8 | Port C bits whose read value comes from the handshake channels |
| hs_status | input | 8 | Handshake status and enable bits for port C reads |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_oe | output | 1 | Port B output enable |
| pc_oe | output | 8 | Port C per-bit output enables |
| grp_a_mode | output | 2 | Group A mode for the handshake channel |
| grp_b_mode | output | 1 | Group B mode for the handshake channel |

## Verification
A write appears on the latch, enable and mode outputs one clock edge after the strobe is first seen low. The bench therefore drives each write at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Read data and `dout_en` are combinational from the strobes, the address and the state. Reads are sampled a short delay after the inputs settle, with no clock edge in between. The multi-cycle strobe case changes `din` after the first rising edge and checks that only the first value lands.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                   b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_strobe.sv
module ppi_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_pulse,
    output logic rd_active
);
    logic wr_act;
    logic wr_seen_d, wr_seen_q;

    always_comb begin
        wr_act    = !cs_n && !wr_n && rd_n;
        rd_active = !cs_n && !rd_n && wr_n;
        wr_seen_d = wr_act;
        wr_pulse  = wr_act && !wr_seen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) wr_seen_q <= 1'b0;
        else     wr_seen_q <= wr_seen_d;
    end
endmodule

// File: rtl/ppi_cmd_decode.sv
module ppi_cmd_decode #(
    parameter int PORT_W = 8,
    localparam int SEL_W = $clog2(PORT_W)
) (
    input  logic [PORT_W-1:0] word,
    output logic              is_mode,
    output ppi_pkg::cfg_t     cfg,
    output logic [SEL_W-1:0]  bit_idx,
    output logic              bit_val
);
    always_comb begin
        is_mode    = word[PORT_W-1];
        cfg.a_mode = word[6:5];
        cfg.a_in   = word[4];
        cfg.cu_in  = word[3];
        cfg.b_mode = word[2];
        cfg.b_in   = word[1];
        cfg.cl_in  = word[0];
        bit_idx    = word[SEL_W:1];
        bit_val    = word[0];
    end
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux #(
    parameter int PORT_W = 8
) (
    input  ppi_pkg::sel_e     sel,
    input  logic              pa_oe,
    input  logic              pb_oe,
    input  logic [PORT_W-1:0] pc_oe,
    input  logic [PORT_W-1:0] pa_q,
    input  logic [PORT_W-1:0] pb_q,
    input  logic [PORT_W-1:0] pc_q,
    input  logic [PORT_W-1:0] pa_in,
    input  logic [PORT_W-1:0] pb_in,
    input  logic [PORT_W-1:0] pc_in,
    input  logic [PORT_W-1:0] hs_owned,
    input  logic [PORT_W-1:0] hs_status,
    output logic [PORT_W-1:0] rdata
);
    logic [PORT_W-1:0] pc_rd;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pc_bit
        always_comb begin
            if (hs_owned[i])   pc_rd[i] = hs_status[i];
            else if (pc_oe[i]) pc_rd[i] = pc_q[i];
            else               pc_rd[i] = pc_in[i];
        end
    end

    always_comb begin
        case (sel)
            ppi_pkg::SEL_A: rdata = pa_oe ? pa_q : pa_in;
            ppi_pkg::SEL_B: rdata = pb_oe ? pb_q : pb_in;
            ppi_pkg::SEL_C: rdata = pc_rd;
            default:        rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppi_regfile.sv
module ppi_regfile #(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    output logic              dout_en,
    input  logic [PORT_W-1:0] pa_in,
    input  logic [PORT_W-1:0] pb_in,
    input  logic [PORT_W-1:0] pc_in,
    input  logic [PORT_W-1:0] hs_owned,
    input  logic [PORT_W-1:0] hs_status,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pc_out,
    output logic              pa_oe,
    output logic              pb_oe,
    output logic [PORT_W-1:0] pc_oe,
    output logic [1:0]        grp_a_mode,
    output logic              grp_b_mode
);
    import ppi_pkg::*;

    localparam int NIB_W = PORT_W / 2;
    localparam int SEL_W = $clog2(PORT_W);

    typedef struct packed {
        cfg_t              cfg;
        logic [PORT_W-1:0] pa;
        logic [PORT_W-1:0] pb;
        logic [PORT_W-1:0] pc;
    } state_t;

    state_t state_d, state_q;

    logic             wr_pulse, rd_active;
    logic             is_mode, bit_val;
    cfg_t             dec_cfg;
    logic [SEL_W-1:0] bit_idx;
    sel_e             sel;

    assign sel = sel_e'(addr);

    ppi_strobe i_strobe (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .wr_pulse  (wr_pulse),
        .rd_active (rd_active)
    );

    ppi_cmd_decode #(.PORT_W(PORT_W)) i_decode (
        .word    (din),
        .is_mode (is_mode),
        .cfg     (dec_cfg),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    always_comb begin
        state_d = state_q;
        if (wr_pulse) begin
            case (sel)
                SEL_A: state_d.pa = din;
                SEL_B: state_d.pb = din;
                SEL_C: state_d.pc[NIB_W-1:0] = din[NIB_W-1:0];
                default: begin
                    if (is_mode) begin
                        state_d.cfg = dec_cfg;
                        state_d.pa  = '0;
                        state_d.pb  = '0;
                        state_d.pc  = '0;
                    end else begin
                        state_d.pc[bit_idx] = bit_val;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '{cfg: CFG_RESET, pa: '0, pb: '0, pc: '0};
        else     state_q <= state_d;
    end

    always_comb begin
        pa_out     = state_q.pa;
        pb_out     = state_q.pb;
        pc_out     = state_q.pc;
        grp_a_mode = state_q.cfg.a_mode;
        grp_b_mode = state_q.cfg.b_mode;
        pa_oe      = !state_q.cfg.a_in && !state_q.cfg.a_mode[1];
        pb_oe      = !state_q.cfg.b_in;
        pc_oe      = {{NIB_W{!state_q.cfg.cu_in && (state_q.cfg.a_mode == 2'b00)}},
                      {NIB_W{!state_q.cfg.cl_in && !state_q.cfg.b_mode}}};
        dout_en    = rd_active && (sel != SEL_CTRL);
    end

    ppi_read_mux #(.PORT_W(PORT_W)) i_rmux (
        .sel       (sel),
        .pa_oe     (pa_oe),
        .pb_oe     (pb_oe),
        .pc_oe     (pc_oe),
        .pa_q      (state_q.pa),
        .pb_q      (state_q.pb),
        .pc_q      (state_q.pc),
        .pa_in     (pa_in),
        .pb_in     (pb_in),
        .pc_in     (pc_in),
        .hs_owned  (hs_owned),
        .hs_status (hs_status),
        .rdata     (dout)
    );
endmodule

// File: rtl/ppi_regfile_chk.sv
module ppi_regfile_chk #(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [PORT_W-1:0] din,
    input logic              dout_en,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] pb_out,
    input logic [PORT_W-1:0] pc_out,
    input logic              pa_oe,
    input logic [1:0]        grp_a_mode
);
    localparam int SEL_W = $clog2(PORT_W);
    localparam int NIB_W = PORT_W / 2;

    logic wa, wa_q, wpulse;
    assign wa     = !cs_n && !wr_n && rd_n;
    assign wpulse = wa && !wa_q;

    always_ff @(posedge clk) begin
        if (rst) wa_q <= 1'b0;
        else     wa_q <= wa;
    end

    assert_bus_release_R7: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (!cs_n && !rd_n && wr_n && addr != 2'd3));

    assert_no_access_R11: assert property (@(posedge clk) disable iff (rst)
        !wa |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    assert_mode_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wpulse && addr == 2'd3 && din[PORT_W-1]) |=>
        (pa_out == '0 && pb_out == '0 && pc_out == '0));

    assert_bit_setclr_R5: assert property (@(posedge clk) disable iff (rst)
        (wpulse && addr == 2'd3 && !din[PORT_W-1]) |=>
        (pc_out[$past(din[SEL_W:1])] == $past(din[0])));

    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (wpulse && addr == 2'd2) |=>
        (pc_out[PORT_W-1:NIB_W] == $past(pc_out[PORT_W-1:NIB_W])));

    assert_bidir_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        grp_a_mode[1] |-> !pa_oe);
endmodule

bind ppi_regfile ppi_regfile_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .din        (din),
    .dout_en    (dout_en),
    .pa_out     (pa_out),
    .pb_out     (pb_out),
    .pc_out     (pc_out),
    .pa_oe      (pa_oe),
    .grp_a_mode (grp_a_mode)
);

// File: tb/test_ppi_regfile.sv
`timescale 1ns/1ps
module test_ppi_regfile;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] hs_owned = 8'h00, hs_status = 8'h00;
    logic [7:0] pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe, grp_b_mode;
    logic [1:0] grp_a_mode;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppi_regfile i_ppi_regfile (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
        .hs_owned(hs_owned), .hs_status(hs_status),
        .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
        .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe),
        .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // write: strobe seen at one rising edge, result sampled at next falling edge
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
        #1;
        d = dout; en = dout_en;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1", "pa_oe", {7'd0, pa_oe}, 8'h00);
        chk("R1", "pb_oe", {7'd0, pb_oe}, 8'h00);
        chk("R1", "pc_oe", pc_oe, 8'h00);
        chk("R1", "latches", pa_out | pb_out | pc_out, 8'h00);
        chk("R1", "modes", {5'd0, grp_a_mode, grp_b_mode}, 8'h00);
        chk("R1", "dout_en", {7'd0, dout_en}, 8'h00);
    endtask

    task automatic t_latch_write();
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h5A);
        bus_write(2'd1, 8'hC3);
        chk("R2", "pa_out", pa_out, 8'h5A);
        chk("R2", "pb_out", pb_out, 8'hC3);
        bus_write(2'd3, 8'h80);
        chk("R4", "pa_out after mode", pa_out, 8'h00);
        chk("R4", "pb_out after mode", pb_out, 8'h00);
    endtask

    task automatic t_mode_fields();
        bus_write(2'd3, 8'h8A);
        chk("R3", "8A pa_oe", {7'd0, pa_oe}, 8'h01);
        chk("R3", "8A pb_oe", {7'd0, pb_oe}, 8'h00);
        chk("R3", "8A pc_oe", pc_oe, 8'h0F);
        bus_write(2'd3, 8'h91);
        chk("R3", "91 pa_oe", {7'd0, pa_oe}, 8'h00);
        chk("R3", "91 pb_oe", {7'd0, pb_oe}, 8'h01);
        chk("R3", "91 pc_oe", pc_oe, 8'hF0);
    endtask

    task automatic t_bit_setclr();
        bus_write(2'd3, 8'h80);
        bus_write(2'd3, 8'h0F);
        chk("R5", "set bit7", pc_out, 8'h80);
        bus_write(2'd3, 8'h75);
        chk("R5", "set bit2, 6:4 ignored", pc_out, 8'h84);
        bus_write(2'd3, 8'h0E);
        chk("R5", "clear bit7", pc_out, 8'h04);
        bus_write(2'd3, 8'h0F);
        bus_write(2'd3, 8'h80);
        chk("R4", "pc_out after mode", pc_out, 8'h00);
    endtask

    task automatic t_portc_write();
        bus_write(2'd3, 8'h80);
        bus_write(2'd3, 8'h0B);
        bus_write(2'd2, 8'hA3);
        chk("R6", "lower only", pc_out, 8'h23);
    endtask

    task automatic t_read_decode();
        logic [7:0] d; logic en;
        bus_read(2'd3, d, en);
        chk("R7", "ctrl read released", {7'd0, en}, 8'h00);
        bus_read(2'd0, d, en);
        chk("R7", "port read drives", {7'd0, en}, 8'h01);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 2'd0; #1;
        chk("R7", "both strobes", {7'd0, dout_en}, 8'h00);
        cs_n = 1'b1; rd_n = 1'b0; wr_n = 1'b1; #1;
        chk("R7", "cs high", {7'd0, dout_en}, 8'h00);
        rd_n = 1'b1;
    endtask

    task automatic t_read_data();
        logic [7:0] d; logic en;
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h3C);
        pa_in = 8'h96;
        bus_read(2'd0, d, en);
        chk("R8", "port A output reads latch", d, 8'h3C);
        bus_write(2'd3, 8'h90);
        bus_read(2'd0, d, en);
        chk("R8", "port A input reads pins", d, 8'h96);
        pb_in = 8'h71;
        bus_write(2'd3, 8'h82);
        bus_read(2'd1, d, en);
        chk("R8", "port B input reads pins", d, 8'h71);
    endtask

    task automatic t_portc_read();
        logic [7:0] d; logic en;
        bus_write(2'd3, 8'h89);
        pc_in = 8'h5A; hs_owned = 8'h0F; hs_status = 8'h03;
        bus_read(2'd2, d, en);
        chk("R9", "status merged with pins", d, 8'h53);
        bus_write(2'd3, 8'h80);
        bus_write(2'd3, 8'h01);
        pc_in = 8'hFF; hs_owned = 8'h80; hs_status = 8'h00;
        bus_read(2'd2, d, en);
        chk("R9", "latch merged with status", d, 8'h01);
        hs_owned = 8'h00;
    endtask

    task automatic t_hs_modes();
        bus_write(2'd3, 8'hC0);
        chk("R10", "mode2 pa_oe", {7'd0, pa_oe}, 8'h00);
        chk("R10", "mode2 pc_oe", pc_oe, 8'h0F);
        chk("R3", "mode2 grp_a_mode", {6'd0, grp_a_mode}, 8'h02);
        bus_write(2'd3, 8'hA4);
        chk("R10", "mode1 pa_oe", {7'd0, pa_oe}, 8'h01);
        chk("R10", "mode1 pc_oe", pc_oe, 8'h00);
        chk("R3", "mode1 groups", {5'd0, grp_a_mode, grp_b_mode}, 8'h03);
    endtask

    task automatic t_no_access();
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h11);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 2'd0; din = 8'hEE;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b1;
        chk("R11", "no write", pa_out, 8'h11);
    endtask

    task automatic t_long_strobe();
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd0; din = 8'h22;
        @(negedge clk);
        din = 8'h33;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        chk("R12", "single write", pa_out, 8'h22);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch_write();
        t_mode_fields();
        t_bit_setclr();
        t_portc_write();
        t_read_decode();
        t_read_data();
        t_portc_read();
        t_hs_modes();
        t_no_access();
        t_long_strobe();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule